// File: doc/BRIEF.md
# Output Frame Sequencer

This block sits on the controller side of an isolated digital output card and drives it over a four-wire serial link that is bit-banged from the system clock. A start request carries a 24-bit frame. The upper byte holds the eight output states, with output 7 in bit 23 and output 0 in bit 16. The lower 16 bits hold two indicator lamps per output: the orange lamp of channel n is at bit 2n and the red lamp at bit 2n+1. The sequencer lowers chip-select and shifts the frame out most significant bit first. Each bit gets a low clock half with the data bit presented, then a high clock half. Raising chip-select afterwards makes the card latch the frame.

The first command after a system reset is preceded by a pulse on the card reset line. The block also has a diagnostic walk. In this mode it switches the outputs on one channel at a time. After each latch it waits a settle interval and samples the synchronised, active-low fault line. For every channel that showed a fault, it sets that channel's red lamp bit. The walk ends with one final frame that carries the commanded outputs together with the accumulated red lamp bits. The fault map is also presented as a port.

Top module: `outcard_seq`

## Requirements
- R1: After system reset: chip-select high, serial clock low, card reset low, busy low, done low, fault map zero.
- R2: The first accepted command after system reset raises the card reset line for exactly RST_CYC cycles, with chip-select high, before chip-select first falls. Later commands produce no reset pulse.
- R3: Chip-select falls before the first clock rise of a frame. Every clock rise happens with chip-select low. Each chip-select low window holds exactly 24 clock rises. Chip-select rises while the clock is low.
- R4: The data line changes only while the clock is low. The bits sampled on the 24 clock rises form the frame from bit 23 down to bit 0. In normal mode this frame equals the commanded word.
- R5: Each high half of the serial clock lasts exactly CLK_DIV system clock cycles.
- R6: busy is high from the cycle after a start is accepted. done is a single-cycle pulse issued in the first cycle in which busy is low again.
- R7: A start request seen while busy is ignored. It sends no frame and leaves no pending command.
- R8: A diagnostic walk sends NCH+1 frames. Frame k (k = 0..NCH-1) has only output bit 16+k set in the upper byte. Its lower 16 bits are the commanded lower bits OR'ed with the red bits (bit 2n+1) of every channel n < k found faulty.
- R9: In a diagnostic walk, the fault line is sampled SETTLE_CYC cycles after the latch window of frame k. A low level sets bit k of the fault map. The map is cleared when a command is accepted and is held while idle.
- R10: The final frame of a walk carries the commanded upper byte. Its lower bits are the commanded lower bits OR'ed with the red bit of every faulty channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| start_i | input | 1 | Command request, taken only while idle |
| diag_i | input | 1 | With start_i: 1 selects the diagnostic walk |
| word_i | input | 24 | Commanded frame (outputs in bits 23..16, lamps below) |
| fault_n_i | input | 1 | Card fault line, active low, asynchronous |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Serial clock to the card |
| mosi_o | output | 1 | Serial data to the card |
| csn_o | output | 1 | Card select, active low; rising edge latches |
| card_rst_o | output | 1 | Card reset, active high |
| fault_map_o | output | 8 | Channels found faulty by the last walk |

## Verification
A corrupted bit counter or shift register appears at the latch edge of the affected frame: the decoded frame is wrong or holds the wrong number of bits, and this is caught as chip-select rises. A wrong timer load shows within one clock half as a high phase of the wrong length, or as a reset pulse of the wrong length. A wrong walk step or a wrong fault-map update produces a wrong output byte or red lamp bits in the next frame, which the card model decodes. It also produces a wrong fault map when done pulses.

// File: rtl/outcard_pkg.sv
package outcard_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST,
        ST_GAP,
        ST_LOAD,
        ST_LOW,
        ST_HIGH,
        ST_LATCH,
        ST_SETTLE
    } seq_state_e;

endpackage

// File: rtl/outcard_timer.sv
module outcard_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          expired_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/outcard_sync.sv
module outcard_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb sh_d = {sh_q[STAGES-2:0], d_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/outcard_frame.sv
module outcard_frame #(
    parameter int NCH = 8,
    localparam int FW = 3 * NCH,
    localparam int SW = $clog2(NCH + 1)
) (
    input  logic [FW-1:0]  base_i,
    input  logic           diag_i,
    input  logic [SW-1:0]  step_i,
    input  logic [NCH-1:0] fmap_i,
    output logic [FW-1:0]  frame_o
);
    logic [2*NCH-1:0] red_bits;
    logic [NCH-1:0]   walk_out;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign red_bits[2*n]   = 1'b0;
        assign red_bits[2*n+1] = fmap_i[n];
        assign walk_out[n]     = (step_i == SW'(n));
    end

    always_comb begin
        if (!diag_i)
            frame_o = base_i;
        else if (step_i < SW'(NCH))
            frame_o = {walk_out, base_i[2*NCH-1:0] | red_bits};
        else
            frame_o = {base_i[FW-1:2*NCH], base_i[2*NCH-1:0] | red_bits};
    end
endmodule

// File: rtl/outcard_seq.sv
module outcard_seq #(
    parameter int NCH         = 8,
    parameter int CLK_DIV     = 50,
    parameter int RST_CYC     = 100,
    parameter int SETTLE_CYC  = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 diag_i,
    input  logic [3*NCH-1:0]     word_i,
    input  logic                 fault_n_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 sclk_o,
    output logic                 mosi_o,
    output logic                 csn_o,
    output logic                 card_rst_o,
    output logic [NCH-1:0]       fault_map_o
);
    import outcard_pkg::*;

    localparam int FW     = 3 * NCH;
    localparam int SW     = $clog2(NCH + 1);
    localparam int BW     = $clog2(FW);
    localparam int MAX_AB = (CLK_DIV > RST_CYC) ? CLK_DIV : RST_CYC;
    localparam int MAXC   = (MAX_AB > SETTLE_CYC) ? MAX_AB : SETTLE_CYC;
    localparam int CW     = $clog2(MAXC + 1);
    localparam logic [CW-1:0] DIV_LD    = CW'(CLK_DIV - 1);
    localparam logic [CW-1:0] RST_LD    = CW'(RST_CYC - 1);
    localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYC - 1);

    typedef struct packed {
        seq_state_e       st;
        logic             inited;
        logic             diag;
        logic [FW-1:0]    base;
        logic [FW-1:0]    shf;
        logic [SW-1:0]    step;
        logic [NCH-1:0]   fmap;
        logic [BW-1:0]    bitn;
        logic             sclk;
        logic             csn;
        logic             crst;
        logic             done;
    } seq_regs_t;

    localparam seq_regs_t REGS_RST = '{
        st: ST_IDLE, inited: 1'b0, diag: 1'b0, base: '0, shf: '0,
        step: '0, fmap: '0, bitn: '0, sclk: 1'b0, csn: 1'b1,
        crst: 1'b0, done: 1'b0
    };

    seq_regs_t     r_d, r_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_exp;
    logic          fault_s;
    logic [FW-1:0] frame_w;

    outcard_timer #(.CW(CW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .val_i     (tmr_val),
        .expired_o (tmr_exp)
    );

    outcard_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_fault_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (fault_n_i),
        .q_o   (fault_s)
    );

    outcard_frame #(.NCH(NCH)) u_frame (
        .base_i  (r_q.base),
        .diag_i  (r_q.diag),
        .step_i  (r_q.step),
        .fmap_i  (r_q.fmap),
        .frame_o (frame_w)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.base = word_i;
                    r_d.diag = diag_i;
                    r_d.step = '0;
                    r_d.fmap = '0;
                    if (!r_q.inited) begin
                        r_d.st   = ST_RST;
                        r_d.crst = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = RST_LD;
                    end else begin
                        r_d.st = ST_LOAD;
                    end
                end
            end
            ST_RST: begin
                if (tmr_exp) begin
                    r_d.crst = 1'b0;
                    r_d.st   = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = DIV_LD;
                end
            end
            ST_GAP: begin
                if (tmr_exp) begin
                    r_d.inited = 1'b1;
                    r_d.st     = ST_LOAD;
                end
            end
            ST_LOAD: begin
                r_d.shf  = frame_w;
                r_d.bitn = '0;
                r_d.csn  = 1'b0;
                r_d.st   = ST_LOW;
                tmr_load = 1'b1;
                tmr_val  = DIV_LD;
            end
            ST_LOW: begin
                if (tmr_exp) begin
                    r_d.sclk = 1'b1;
                    r_d.st   = ST_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = DIV_LD;
                end
            end
            ST_HIGH: begin
                if (tmr_exp) begin
                    r_d.sclk = 1'b0;
                    r_d.shf  = {r_q.shf[FW-2:0], 1'b0};
                    tmr_load = 1'b1;
                    tmr_val  = DIV_LD;
                    if (r_q.bitn == BW'(FW - 1)) begin
                        r_d.csn = 1'b1;
                        r_d.st  = ST_LATCH;
                    end else begin
                        r_d.bitn = r_q.bitn + 1'b1;
                        r_d.st   = ST_LOW;
                    end
                end
            end
            ST_LATCH: begin
                if (tmr_exp) begin
                    if (r_q.diag && (r_q.step != SW'(NCH))) begin
                        r_d.st   = ST_SETTLE;
                        tmr_load = 1'b1;
                        tmr_val  = SETTLE_LD;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_exp) begin
                    r_d.fmap = r_q.fmap |
                               ({{(NCH-1){1'b0}}, ~fault_s} << r_q.step);
                    r_d.step = r_q.step + 1'b1;
                    r_d.st   = ST_LOAD;
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = r_q.done;
    assign sclk_o      = r_q.sclk;
    assign csn_o       = r_q.csn;
    assign card_rst_o  = r_q.crst;
    assign mosi_o      = r_q.shf[FW-1] & ~r_q.csn;
    assign fault_map_o = r_q.fmap;
endmodule

// File: rtl/outcard_seq_chk.sv
module outcard_seq_chk #(
    parameter int NCH     = 8,
    parameter int CLK_DIV = 50
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic           busy_o,
    input logic           done_o,
    input logic           sclk_o,
    input logic           mosi_o,
    input logic           csn_o,
    input logic           card_rst_o,
    input logic [NCH-1:0] fault_map_o
);
    int hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hi_cnt_q <= 0;
        else if (sclk_o) hi_cnt_q <= hi_cnt_q + 1;
        else             hi_cnt_q <= 0;
    end

    a_r3_clock_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !csn_o);

    a_r3_latch_with_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csn_o) |-> !sclk_o);

    a_r2_reset_while_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst_o |-> csn_o);

    a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    a_r5_high_half_length: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_o && $past(sclk_o)) |-> (hi_cnt_q == CLK_DIV));

    a_r6_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_map_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(fault_map_o));
endmodule

bind outcard_seq outcard_seq_chk #(.NCH(NCH), .CLK_DIV(CLK_DIV)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .csn_o       (csn_o),
    .card_rst_o  (card_rst_o),
    .fault_map_o (fault_map_o)
);

// File: tb/outcard_seq_tb_top.sv
module outcard_seq_tb_top;
    localparam int NCH    = 8;
    localparam int FW     = 24;
    localparam int DIV    = 3;
    localparam int RSTC   = 7;
    localparam int SETTLE = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic diag_i = 1'b0;
    logic [FW-1:0] word_i = '0;
    logic fault_n_i;
    logic busy_o, done_o, sclk_o, mosi_o, csn_o, card_rst_o;
    logic [NCH-1:0] fault_map_o;

    always #5 clk = ~clk;

    outcard_seq #(.NCH(NCH), .CLK_DIV(DIV), .RST_CYC(RSTC),
                  .SETTLE_CYC(SETTLE), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .diag_i(diag_i),
        .word_i(word_i), .fault_n_i(fault_n_i), .busy_o(busy_o),
        .done_o(done_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .csn_o(csn_o),
        .card_rst_o(card_rst_o), .fault_map_o(fault_map_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // card model and serial monitor
    logic [NCH-1:0] bad_mask = '0;
    logic [NCH-1:0] card_out = '0;
    logic [FW-1:0]  acc = '0;
    logic [FW-1:0]  got_q[$];
    int nbits = 0, hi_cnt = 0, rst_cnt = 0, rst_pulses = 0;
    logic p_sclk = 1'b0, p_csn = 1'b1, p_rst = 1'b0, p_mosi = 1'b0;

    assign fault_n_i = ~|(card_out & bad_mask);

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk_o && !p_sclk) begin
                if (csn_o) chk(1'b0, "R3", "clock rise while deselected", 1, 0);
                acc = {acc[FW-2:0], mosi_o};
                nbits++;
            end
            if (sclk_o && p_sclk && (mosi_o != p_mosi))
                chk(1'b0, "R4", "data moved during high clock", mosi_o, p_mosi);
            if (!sclk_o && p_sclk)
                chk(hi_cnt == DIV, "R5", "high half length", hi_cnt, DIV);
            if (!csn_o && p_csn) begin
                nbits = 0;
                chk(rst_pulses >= 1, "R2", "card reset before first select", rst_pulses, 1);
            end
            if (csn_o && !p_csn) begin
                chk(nbits == FW, "R3", "bits per select window", nbits, FW);
                chk(!sclk_o, "R3", "clock level at latch", sclk_o, 0);
                got_q.push_back(acc);
                card_out = acc[FW-1:2*NCH];
            end
            if (!card_rst_o && p_rst) begin
                chk(rst_cnt == RSTC, "R2", "card reset length", rst_cnt, RSTC);
                rst_pulses++;
            end
            hi_cnt  = sclk_o ? hi_cnt + 1 : 0;
            rst_cnt = card_rst_o ? rst_cnt + 1 : 0;
        end
        p_sclk = sclk_o; p_csn = csn_o; p_rst = card_rst_o; p_mosi = mosi_o;
    end

    // watchdog
    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [2*NCH-1:0] red_of(input logic [NCH-1:0] m);
        logic [2*NCH-1:0] r = '0;
        for (int i = 0; i < NCH; i++) r[2*i+1] = m[i];
        return r;
    endfunction

    task automatic run_cmd(input logic [FW-1:0] w, input bit dg,
                           input logic [NCH-1:0] bad, input bit intrude,
                           input string req);
        logic [FW-1:0] exp_q[$];
        logic [NCH-1:0] m = '0;
        int pulses0, n;
        bad_mask = bad;
        got_q.delete();
        pulses0 = rst_pulses;
        if (!dg) exp_q.push_back(w);
        else begin
            for (int k = 0; k < NCH; k++) begin
                exp_q.push_back({NCH'(1) << k, w[2*NCH-1:0] | red_of(m)});
                m[k] = bad[k];
            end
            exp_q.push_back({w[FW-1:2*NCH], w[2*NCH-1:0] | red_of(m)});
        end
        @(negedge clk);
        start_i = 1'b1; word_i = w; diag_i = dg;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R6", "busy after accepted start", busy_o, 1);
        n = 0;
        while (!done_o) begin
            @(negedge clk);
            n++;
            if (intrude && n == 40) begin start_i = 1'b1; word_i = 24'h123456; diag_i = 1'b1; end
            if (intrude && n == 45) start_i = 1'b0;
        end
        chk(!busy_o, "R6", "busy low with done", busy_o, 0);
        chk(got_q.size() == exp_q.size(), req, "frame count", got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk(got_q[i] == exp_q[i], req, $sformatf("frame %0d", i), got_q[i], exp_q[i]);
        if (pulses0 == 0)
            chk(rst_pulses == 1, "R2", "reset pulse on first command", rst_pulses, 1);
        else
            chk(rst_pulses == pulses0, "R2", "no reset on later command", rst_pulses, pulses0);
        if (dg) chk(fault_map_o == bad, "R9", "fault map", fault_map_o, bad);
        @(negedge clk);
        chk(!done_o, "R6", "done single cycle", done_o, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(csn_o && !sclk_o && !card_rst_o && !busy_o && !done_o && fault_map_o == '0,
            "R1", "reset state", {csn_o, sclk_o, card_rst_o, busy_o, done_o}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(csn_o && !sclk_o && !busy_o, "R1", "state after reset release",
            {csn_o, sclk_o, busy_o}, 3'b100);

        run_cmd(24'hA53C96, 1'b0, '0, 1'b0, "R4");
        run_cmd(24'hFFFFFF, 1'b0, '0, 1'b0, "R4");
        run_cmd(24'h000000, 1'b0, '0, 1'b0, "R4");
        run_cmd(24'h800001, 1'b0, '0, 1'b0, "R4");
        // R7: intruding start during a frame
        run_cmd(24'h5A0FF0, 1'b0, '0, 1'b1, "R7");
        repeat (20) @(negedge clk);
        chk(!busy_o && got_q.size() == 1, "R7", "no pending command after ignored start",
            {busy_o, 8'(got_q.size())}, 1);

        run_cmd(24'h005555, 1'b1, 8'h00, 1'b0, "R8");
        run_cmd(24'hC30000, 1'b1, 8'h24, 1'b0, "R8");
        run_cmd(24'h81FFFF, 1'b1, 8'hFF, 1'b0, "R10");
        run_cmd(24'h000000, 1'b1, 8'h80, 1'b0, "R9");
        run_cmd(24'h3C00AA, 1'b1, 8'h01, 1'b0, "R10");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule